// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic use a 32K x 8 asynchronous static RAM. It has active-low chip-select, write-strobe and output-gate pins. The host makes one request at a time. It raises `req` with a write flag, a 15-bit address and a byte of write data. The controller latches these when it is idle, runs one memory cycle and pulses `done`. For a read, the captured byte is on `rdata` during the `done` cycle.

On the memory side the controller drives the address and the three strobes. The bidirectional byte bus is split into three signals: an outgoing byte, a driver enable and an incoming byte. The write strobe times each write, and the output gate stays high for the whole write. The controller turns its data driver on only after the output gate has been high for at least one cycle.

All memory timing is given in nanoseconds and converted to whole clock cycles. The defaults assume a 100 MHz clock and a 10 ns part.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `done` is 0.
- R2: A read (`we_req`=0) holds `mem_ce_n`=0 and `mem_we_n`=1. It holds `mem_oe_n`=0 for RD cycles, with `mem_dq_oe`=0 throughout. It then returns the byte stored at the latched address on `rdata`.
- R3: During a write (`we_req`=1), `mem_we_n` is 0 for WR cycles. In each of those cycles `mem_ce_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1, and `mem_dq_out` carries the write byte. The byte lands at the latched address.
- R4: `mem_dq_oe` is 1 only in a cycle where `mem_oe_n` is 1 and was also 1 in the previous cycle.
- R5: While `mem_we_n` stays 0, `mem_addr` and `mem_dq_out` do not change.
- R6: With T the clock period, define:
  - RD = max(ceil(tAA/T), ceil(tOE/T))
  - WR = max(ceil(tWP/T), ceil(tWC/T)-1)
  - REC = max(1, ceil(tHZ/T))

  `done` rises in cycle 1+RD+REC after the accepting edge for a read, and in cycle 1+WR+REC for a write.
- R7: `done` is high for exactly one cycle per accepted request.
- R8: `req` is ignored while an access is in progress. Holding it high during an access starts no second access.
- R9: `rdata` keeps its value until the next read completes. Writes leave it unchanged.
- R10: In the `done` cycle, all three strobes are inactive high.
- R11: The address and write byte are latched at acceptance, so host inputs may change once the request has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when idle |
| we_req | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Word address |
| wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 15 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The assertions watch the strobe combinations on every cycle:
- no write strobe without chip select and a high output gate;
- no output gate during a write or while the driver is on;
- the driver waits one cycle after the gate rises;
- the address and data hold still under the write strobe;
- `done` is a single-cycle pulse with the memory deselected.

Only the bench scenarios can show the rest:
- the exact cycle counts;
- that bytes reach and return from the right addresses;
- that `req` is ignored during an access;
- that `rdata` holds across writes.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int T_CLK_NS = 10,
  parameter int T_AA_NS  = 10,
  parameter int T_OE_NS  = 5,
  parameter int T_WP_NS  = 7,
  parameter int T_WC_NS  = 10,
  parameter int T_HZ_NS  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int C_AA = (T_AA_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int C_OE = (T_OE_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int C_WP = (T_WP_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int C_WC = (T_WC_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int C_HZ = (T_HZ_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int RD0  = (C_AA > C_OE) ? C_AA : C_OE;
  localparam int RD   = (RD0 > 1) ? RD0 : 1;
  localparam int WR0  = (C_WP > C_WC - 1) ? C_WP : C_WC - 1;
  localparam int WR   = (WR0 > 1) ? WR0 : 1;
  localparam int REC  = (C_HZ > 1) ? C_HZ : 1;
  localparam int MX0  = (RD > WR) ? RD : WR;
  localparam int MX   = (MX0 > REC) ? MX0 : REC;
  localparam int CW   = $clog2(MX + 1);

  typedef enum logic [2:0] {IDLE, SETUP, READ_WAIT, WRITE_PULSE, RECOVER} state_t;

  state_t        state;
  logic [CW-1:0] cnt, limit;
  logic          wr_q, last;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  always_comb begin
    case (state)
      READ_WAIT:   limit = CW'(RD - 1);
      WRITE_PULSE: limit = CW'(WR - 1);
      RECOVER:     limit = CW'(REC - 1);
      default:     limit = '0;
    endcase
  end

  assign last = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
    end else begin
      case (state)
        IDLE: if (req) begin
          a_q   <= addr;
          d_q   <= wdata;
          wr_q  <= we_req;
          cnt   <= '0;
          state <= SETUP;
        end
        SETUP: begin
          cnt   <= '0;
          state <= wr_q ? WRITE_PULSE : READ_WAIT;
        end
        READ_WAIT: if (last) begin
          rdata <= mem_dq_in;
          cnt   <= '0;
          state <= RECOVER;
        end else cnt <= cnt + 1'b1;
        WRITE_PULSE: if (last) begin
          cnt   <= '0;
          state <= RECOVER;
        end else cnt <= cnt + 1'b1;
        RECOVER: if (last) begin
          cnt   <= '0;
          state <= IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= IDLE;
      endcase
    end
  end

  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;
  assign mem_ce_n   = !(state == SETUP || state == READ_WAIT || state == WRITE_PULSE);
  assign mem_oe_n   = (state != READ_WAIT);
  assign mem_we_n   = (state != WRITE_PULSE);
  assign mem_dq_oe  = wr_q && (state == SETUP || state == WRITE_PULSE);
  assign done       = (state == RECOVER) && last;
endmodule

module sram_ctrl_chk #(parameter int AW = 15, parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  assert_write_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n && mem_oe_n && mem_dq_oe);
  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n && mem_we_n && !mem_dq_oe);
  assert_driver_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n && $past(mem_oe_n));
  assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr) && $stable(mem_dq_out));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_ce_n && mem_we_n && mem_oe_n);
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
  localparam int TCLK = 4;
  localparam int RD  = 3;  // R6: max(ceil(10/4), ceil(5/4))
  localparam int WR  = 2;  // R6: max(ceil(7/4), ceil(10/4)-1)
  localparam int REC = 1;  // R6: max(1, ceil(4/4))

  logic clk = 0, rst_n = 0, req = 0, we_req = 0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rdata, mem_dq_out, mem_dq_in;
  logic [14:0] mem_addr;
  logic [7:0] mem [0:32767];
  int n_chk = 0, n_fail = 0;

  typedef struct { bit wr; logic [14:0] a; logic [7:0] d; } exp_t;
  exp_t q[$];

  always #(TCLK/2) clk = ~clk;

  sram_ctrl #(.T_CLK_NS(TCLK)) u_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we_req(we_req), .addr(addr), .wdata(wdata),
    .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : 8'hEE;

  always @(negedge clk) if (!mem_ce_n && !mem_we_n) mem[mem_addr] <= mem_dq_out;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(negedge clk) if (rst_n && done) begin
    if (q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
    else begin
      exp_t e;
      e = q.pop_front();
      if (e.wr) chk(mem[e.a] == e.d, "R3 write stored", mem[e.a], e.d);
      else      chk(rdata == e.d, "R2 read data", rdata, e.d);
    end
  end

  task automatic op(input bit w, input logic [14:0] a, input logic [7:0] d, input bit hold);
    int n;
    exp_t e;
    e.wr = w; e.a = a; e.d = w ? d : mem[a];
    q.push_back(e);
    @(negedge clk); req = 1; we_req = w; addr = a; wdata = d;
    @(negedge clk); n = 1;
    if (!hold) req = 0;
    addr = ~a; wdata = ~d; // R11: inputs change after acceptance
    @(negedge clk); n = 2;
    if (w) chk(!mem_we_n && !mem_ce_n && mem_oe_n && mem_dq_oe && mem_dq_out == d,
               "R3 write strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
    else   chk(!mem_oe_n && !mem_ce_n && mem_we_n && !mem_dq_oe,
               "R2 read strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0100);
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk(n == (w ? 1 + WR + REC : 1 + RD + REC), "R6 latency", n, w ? 1 + WR + REC : 1 + RD + REC);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R10 strobes idle at done",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 32768; i++) mem[i] = 8'(i) ^ 8'(i >> 7);
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !done, "R1 reset outputs",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, done}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !done, "R1 after reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, done}, 5'b11100);

    op(0, 15'h0000, 8'h00, 0);
    op(0, 15'h7FFF, 8'h00, 0);
    op(0, 15'h1234, 8'h00, 0);
    op(1, 15'h0000, 8'hA5, 0);
    op(1, 15'h7FFF, 8'h5A, 0);
    op(1, 15'h0055, 8'hFF, 0);
    op(1, 15'h0056, 8'h00, 0);
    op(0, 15'h0000, 8'h00, 0);
    op(0, 15'h7FFF, 8'h00, 0);
    op(0, 15'h0055, 8'h00, 0);
    op(0, 15'h0056, 8'h00, 0);

    held = rdata;
    op(1, 15'h0100, 8'h3C, 0);
    chk(rdata == held, "R9 rdata held over write", rdata, held);

    op(0, 15'h0100, 8'h00, 1); // R8: req held high through the access
    begin
      bit quiet = 1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!mem_ce_n || done) quiet = 0;
      end
      chk(quiet, "R8 req ignored while busy", quiet, 1);
    end
    chk(rdata == 8'h3C, "R9 rdata after read", rdata, 8'h3C);
    chk(q.size() == 0, "R7 one done per request", q.size(), 0);
    report();
    $finish;
  end
endmodule